// File: doc/BRIEF.md
# Software-Triggered Reset Controller

This block holds one 32-bit control register through which software can reset a single peripheral domain, or a whole group of domains, by writing ones. Each accepted request starts a fixed-length, active-high reset pulse on the domain outputs it covers. While a pulse runs, its register bit reads 1. The bit clears by itself once the pulse is over, so software can poll for completion.

There are three grouped requests. The soft request covers every domain except the CPU and the watchdog. The peripheral request also spares both GPIO ports. The system request covers everything, including the CPU and the watchdog. While the system request is running, the register block counts as being in reset and ignores every write. The bit that resets the random-number generator only has an effect while the test-mode input is high.

Top module: `swrst_ctrl`

## Requirements
- R1: After the power-on reset `rst_ni` is released, every domain output, `cpu_rst_o` and all bits of `rd_data_o` are 0.
- R2: Writing 1 to domain bit b (0 DMA, 1 watchdog, 2–3 GPIO ports, 4–7 timers, 8–10 UARTs, 11 SPI, 12 I2C, 13 RTC, 14 semaphore, 15 RNG, 16 CNN accelerator, 17 ADC) drives `dom_rst_o[b]` high for exactly 8 cycles, starting in the cycle after the write. Read bit b is 1 in exactly those cycles.
- R3: Writing 0 to any bit has no effect. Bits 18 to 28 are unused: they always read 0, and writing them starts nothing.
- R4: Writing 1 to a domain bit whose pulse is already running neither restarts nor extends that pulse.
- R5: Bit 15 (RNG) starts a pulse only when `test_mode_i` is 1 during the write. When `test_mode_i` is 0 the write is ignored.
- R6: Bit 29 (soft) pulses every domain output except bit 1 (watchdog). It does not assert `cpu_rst_o`.
- R7: Bit 30 (peripheral) pulses every domain output except bits 1, 2 and 3. It does not assert `cpu_rst_o`.
- R8: Bit 31 (system) pulses all 18 domain outputs and `cpu_rst_o` together.
- R9: A group bit reads 1 from the cycle after its write until one cycle after the last covered pulse has ended. Writing it again while it reads 1 restarts nothing.
- R10: While bit 31 reads 1, all writes are ignored. Once it clears, every register bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| test_mode_i | input | 1 | Manufacturing test mode; enables the RNG reset bit |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value (busy bits) |
| dom_rst_o | output | 18 | Active-high reset, one per domain, indexed like the register bits |
| cpu_rst_o | output | 1 | Active-high CPU core reset |

## Verification
The hardest case to reach is a write arriving while another reset is still in flight: a repeated write to a running bit, a repeated group write, or a domain write during a system reset. Each of these must leave the pulse end times unchanged. The stimulus places these second writes at chosen cycle offsets inside a running pulse. It then checks, at each sample point, that the pulses still end 8 cycles after the first write and that nothing new starts. A sweep over every register bit, with and without test mode, covers the per-domain mapping and the ignored bits.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
   localparam int NUM_DOM  = 18;
   localparam int CH_DMA   = 0;
   localparam int CH_WDT   = 1;
   localparam int CH_GPIO0 = 2;
   localparam int CH_GPIO1 = 3;
   localparam int CH_RNG   = 15;
   localparam int CH_CPU   = NUM_DOM;
   localparam int NUM_CH   = NUM_DOM + 1;

   localparam int NUM_GRP      = 3;
   localparam int GRP_SOFT     = 0;
   localparam int GRP_PERIPH   = 1;
   localparam int GRP_SYS      = 2;
   localparam int GRP_BIT_BASE = 29;

   typedef logic [NUM_CH-1:0] ch_vec_t;

   // Channels covered by each grouped request
   function automatic ch_vec_t grp_mask(int g);
      ch_vec_t m;
      m = '1;
      if (g != GRP_SYS) begin
         m[CH_CPU] = 1'b0;
         m[CH_WDT] = 1'b0;
      end
      if (g == GRP_PERIPH) begin
         m[CH_GPIO0] = 1'b0;
         m[CH_GPIO1] = 1'b0;
      end
      return m;
   endfunction
endpackage

// File: rtl/swrst_pulse_chan.sv
module swrst_pulse_chan #(
   parameter int unsigned PULSE_CYCLES = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic active_o
);
   if (PULSE_CYCLES < 1) begin : g_bad_len
      $error("PULSE_CYCLES must be at least 1");
   end

   if (PULSE_CYCLES == 1) begin : g_flop
      logic act_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      act_q <= 1'b0;
         else if (act_q)   act_q <= 1'b0;
         else              act_q <= start_i;
      end
      assign active_o = act_q;
   end else begin : g_count
      localparam int CW = $clog2(PULSE_CYCLES + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            cnt_q <= '0;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
         else if (start_i)
            cnt_q <= CW'(PULSE_CYCLES);
      end
      assign active_o = (cnt_q != '0);
   end
endmodule

// File: rtl/swrst_group_track.sv
module swrst_group_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic covered_busy_i,
   output logic busy_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              busy_o <= 1'b0;
      else if (start_i)         busy_o <= 1'b1;
      else if (!covered_busy_i) busy_o <= 1'b0;
   end
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
   import swrst_pkg::*;
#(
   parameter int unsigned PULSE_CYCLES = 8,
   parameter int unsigned DATA_W       = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                test_mode_i,
   input  logic                wr_en_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   output logic [DATA_W-1:0]   rd_data_o,
   output logic [NUM_DOM-1:0]  dom_rst_o,
   output logic                cpu_rst_o
);
   if (DATA_W < GRP_BIT_BASE + NUM_GRP) begin : g_bad_width
      $error("DATA_W too small for the group bits");
   end

   ch_vec_t              ch_act;
   ch_vec_t              ch_req;
   logic [NUM_GRP-1:0]   grp_busy;
   logic [NUM_GRP-1:0]   grp_start;
   logic                 wr_ok;

   // The register block itself is held in reset during a system reset
   assign wr_ok = wr_en_i & ~grp_busy[GRP_SYS];

   always_comb begin
      ch_req = '0;
      if (wr_ok) ch_req[NUM_DOM-1:0] = wr_data_i[NUM_DOM-1:0];
      if (!test_mode_i) ch_req[CH_RNG] = 1'b0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (grp_start[g]) ch_req = ch_req | grp_mask(g);
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      swrst_pulse_chan #(.PULSE_CYCLES(PULSE_CYCLES)) chan_i (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .start_i  (ch_req[c]),
         .active_o (ch_act[c])
      );
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam ch_vec_t MASK = grp_mask(g);
      assign grp_start[g] = wr_ok & wr_data_i[GRP_BIT_BASE+g] & ~grp_busy[g];
      swrst_group_track trk_i (
         .clk_i          (clk_i),
         .rst_ni         (rst_ni),
         .start_i        (grp_start[g]),
         .covered_busy_i (|(ch_act & MASK)),
         .busy_o         (grp_busy[g])
      );
   end

   always_comb begin
      rd_data_o = '0;
      rd_data_o[NUM_DOM-1:0] = ch_act[NUM_DOM-1:0];
      for (int g = 0; g < NUM_GRP; g++) begin
         rd_data_o[GRP_BIT_BASE+g] = grp_busy[g];
      end
   end

   assign dom_rst_o = ch_act[NUM_DOM-1:0];
   assign cpu_rst_o = ch_act[CH_CPU];
endmodule

// File: rtl/swrst_ctrl_chk.sv
module swrst_ctrl_chk
   import swrst_pkg::*;
#(
   parameter int unsigned PULSE_CYCLES = 8,
   parameter int unsigned DATA_W       = 32
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                test_mode_i,
   input logic                wr_en_i,
   input logic [DATA_W-1:0]   wr_data_i,
   input logic [DATA_W-1:0]   rd_data_o,
   input logic [NUM_DOM-1:0]  dom_rst_o,
   input logic                cpu_rst_o
);
   localparam int SYS_BIT = GRP_BIT_BASE + GRP_SYS;
   localparam int PER_BIT = GRP_BIT_BASE + GRP_PERIPH;
   localparam int SFT_BIT = GRP_BIT_BASE + GRP_SOFT;

   logic [15:0] hi_cnt;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          hi_cnt <= '0;
      else if (dom_rst_o[CH_DMA]) hi_cnt <= hi_cnt + 16'd1;
      else                  hi_cnt <= '0;
   end

   // R2: DMA pulse lasts exactly PULSE_CYCLES
   a_r2_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dom_rst_o[CH_DMA]) |-> (hi_cnt == 16'(PULSE_CYCLES)));

   // R2: accepted write of bit 0 starts the DMA pulse
   a_r2_write_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[CH_DMA] && !rd_data_o[SYS_BIT]) |=> dom_rst_o[CH_DMA]);

   // R5: RNG bit ignored outside test mode
   a_r5_rng_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[CH_RNG] && !test_mode_i && !dom_rst_o[CH_RNG]
       && (wr_data_i[SYS_BIT:SFT_BIT] == '0)) |=> !dom_rst_o[CH_RNG]);

   // R7: peripheral group leaves GPIO idle
   a_r7_gpio_spared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !rd_data_o[SYS_BIT] && (wr_data_i == (DATA_W'(1) << PER_BIT))
       && (dom_rst_o[CH_GPIO1:CH_GPIO0] == 2'b00)) |=> (dom_rst_o[CH_GPIO1:CH_GPIO0] == 2'b00));

   // R8: only a system request raises the CPU reset
   a_r8_cpu_only_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cpu_rst_o) |-> $past(wr_en_i && wr_data_i[SYS_BIT]));

   // R9: soft group clears only after its covered pulses end
   a_r9_group_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rd_data_o[SFT_BIT]) |-> ((dom_rst_o & ~NUM_DOM'(1 << CH_WDT)) == '0));

   // R10: all bits zero when the system reset finishes
   a_r10_sys_clears_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rd_data_o[SYS_BIT]) |-> (rd_data_o == '0));
endmodule

bind swrst_ctrl swrst_ctrl_chk #(.PULSE_CYCLES(PULSE_CYCLES), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/swrst_ctrl_tb_top.sv
module swrst_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 18;
   localparam int PL = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          test_mode = 1'b0;
   logic          wr_en = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic [ND-1:0] dom_rst;
   logic          cpu_rst;
   int            n_chk = 0;
   int            n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   swrst_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
      .dom_rst_o(dom_rst), .cpu_rst_o(cpu_rst)
   );

   localparam logic [ND-1:0] ALL_DOM = '1;
   localparam logic [ND-1:0] SOFT_D  = ALL_DOM & ~ND'(32'h2);
   localparam logic [ND-1:0] PER_D   = ALL_DOM & ~ND'(32'hE);

   task automatic expect_st(string tag, logic [ND-1:0] d_exp, logic c_exp, logic [31:0] r_exp);
      n_chk++;
      if (dom_rst !== d_exp || cpu_rst !== c_exp || rd_data !== r_exp) begin
         n_fail++;
         $display("FAIL %s: dom=%h cpu=%b rd=%h expected dom=%h cpu=%b rd=%h",
                  tag, dom_rst, cpu_rst, rd_data, d_exp, c_exp, r_exp);
      end
   endtask

   // Called at a negedge; returns at the negedge after the capturing edge
   task automatic do_write(logic [31:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // Single write, then 10 sample points; grp < 0 means no group bit
   task automatic run_pulse(string tag, logic [31:0] d, logic [ND-1:0] d_exp, logic c_exp, int grp);
      do_write(d);
      for (int k = 0; k < PL + 2; k++) begin
         logic [ND-1:0] de;
         logic [31:0]   re;
         de = (k < PL) ? d_exp : '0;
         re = 32'(de);
         if (grp >= 0 && k < PL + 1) re[grp] = 1'b1;
         expect_st(tag, de, (k < PL) ? c_exp : 1'b0, re);
         @(negedge clk);
      end
      idle(2);
   endtask

   initial begin
      repeat (PL * 2000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_st("R1 reset state", '0, 1'b0, '0);

      // R2 / R5: sweep every domain bit, both test-mode settings
      for (int tm = 0; tm < 2; tm++) begin
         for (int b = 0; b < ND; b++) begin
            logic [ND-1:0] e;
            test_mode = tm[0];
            e = ND'(1) << b;
            if (b == 15 && tm == 0) e = '0;
            run_pulse((b == 15) ? "R5 rng gate" : "R2 domain pulse", 32'(1) << b, e, 1'b0, -1);
         end
      end
      test_mode = 1'b0;

      // R3: zero write and unused bits
      run_pulse("R3 zero write", 32'h0, '0, 1'b0, -1);
      run_pulse("R3 unused bits", 32'h1FFC_0000, '0, 1'b0, -1);

      // R6 / R7 / R8 groups
      run_pulse("R6 soft group", 32'h2000_0000, SOFT_D, 1'b0, 29);
      run_pulse("R7 periph group", 32'h4000_0000, PER_D, 1'b0, 30);
      run_pulse("R8 sys group", 32'h8000_0000, ALL_DOM, 1'b1, 31);

      // R4: rewrite a running bit at k=3
      do_write(32'h10);
      for (int k = 0; k < PL + 2; k++) begin
         logic [ND-1:0] de;
         de = (k < PL) ? ND'(32'h10) : '0;
         expect_st("R4 no extend", de, 1'b0, 32'(de));
         if (k == 3) do_write(32'h10); else @(negedge clk);
      end
      idle(2);

      // R9: rewrite soft group at k=4
      do_write(32'h2000_0000);
      for (int k = 0; k < PL + 2; k++) begin
         logic [ND-1:0] de;
         logic [31:0]   re;
         de = (k < PL) ? SOFT_D : '0;
         re = 32'(de);
         re[29] = (k < PL + 1);
         expect_st("R9 group rewrite", de, 1'b0, re);
         if (k == 4) do_write(32'h2000_0000); else @(negedge clk);
      end
      idle(2);

      // R10: domain write during system reset is ignored
      do_write(32'h8000_0000);
      for (int k = 0; k < PL + 4; k++) begin
         logic [ND-1:0] de;
         logic [31:0]   re;
         de = (k < PL) ? ALL_DOM : '0;
         re = 32'(de);
         re[31] = (k < PL + 1);
         expect_st("R10 writes ignored in sys", de, k < PL, re);
         if (k == 2) do_write(32'h6000_0001); else @(negedge clk);
      end
      idle(2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule